// File: doc/BRIEF.md
# Interrupt Request Hub with Halt Control

This block collects single-cycle event pulses from fourteen on-chip sources and holds each one in a request register until software acknowledges it. A sixteen-bit enable register selects which requests may interrupt the processor, and a one-bit master switch gates the processor interrupt line. Software reaches all of this through a small register bus. The bus carries byte, halfword and word accesses, with write data and read data aligned to bit 0 and the byte offset given on the address.

Software clears a request by writing a one to its bit. One word write can replace the enable register and acknowledge requests in the same access. A byte register also sits on the bus. Writing it parks the processor with a halt request, which lasts until an enabled request is pending. A one-bit boot flag shares that register word.

Source bit assignment: bit 0 frame blank, bit 1 line blank, bit 2 line-count match, bits 3 to 6 timer 0 to 3 overflow, bit 7 serial link, bits 8 to 11 block-copy channels 0 to 3, bit 12 keypad, bit 13 cartridge.

Top module: `irq_hub`

## Requirements
- R1: After reset the enable register, request register, master switch, boot flag, `cpu_irq` and `halt_req` are all 0.
- R2: A 1 on `src_pulse[i]` at a rising clock edge sets request bit i, visible from that edge onward. The bit stays set until it is acknowledged.
- R3: A halfword write (`bus_size`=1) at offset 0x202 clears each request bit written as 1 and leaves bits written as 0 unchanged.
- R4: A word write (`bus_size`=2) at offset 0x200 loads the enable register from data bits 15:0. In the same access it clears the request bits selected by ones in data bits 31:16.
- R5: A word read at 0x200 returns {request, enable}. A halfword read at 0x200 returns enable and one at 0x202 returns request. A byte read (`bus_size`=0) at 0x200+k returns byte k of that word. Byte writes at 0x200 and 0x201 load single enable bytes.
- R6: The master switch at offset 0x208 keeps only data bit 0 of a write of any width. A read returns that bit zero-extended.
- R7: `cpu_irq` is 1 exactly when the master switch is 1 and the AND of enable and request is nonzero.
- R8: If a source pulse and an acknowledge hit the same request bit in one cycle, that bit stays set.
- R9: Bits 15:14 of the enable and request registers always read 0.
- R10: A byte write at 0x301 with data bit 7 = 0 raises `halt_req` at the next edge. The same write with bit 7 = 1 leaves `halt_req` unchanged.
- R11: While `halt_req` is 1, it falls at the first edge where the AND of enable and request is nonzero, whatever the master switch holds.
- R12: The byte at 0x300 holds a boot flag in bit 0. It reads 0 after reset and reads back the last bit 0 written. A read at 0x301 returns 0.
- R13: Reads of unmapped offsets, misaligned accesses (halfword at an odd offset, word at an offset that is not a multiple of 4) and `bus_size`=3 return 0, and their writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | 14 | One-cycle event pulses, one per source |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no access |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wdata | input | 32 | Write value, aligned to bit 0 |
| bus_rdata | output | 32 | Read value, aligned to bit 0, combinational, 0 when no read |
| cpu_irq | output | 1 | Interrupt line to the processor |
| halt_req | output | 1 | Processor halt request |

## Verification
A request bit that is lost, stuck or cleared by the wrong byte lane shows up on the next register read, one cycle after the edge that produced it. If the enable is also set, it shows up at once on `cpu_irq`. A halt flop that does not wake is visible on `halt_req` one edge after the enabled request appears, and it stays visible even with the master switch off. Lane and alignment faults in the decode show up as wrong or missing bytes in a read of the same cycle. The scoreboard compares every read against a value worked out from the register rules alone.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_NONE = 2'd3
  } acc_size_e;

  // Byte lanes touched by an access; zero for misaligned or absent sizes.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
    logic [LANES-1:0] m;
    case (acc_size_e'(size))
      ACC_BYTE: m = 4'b0001 << off;
      ACC_HALF: m = off[0] ? 4'b0000 : (off[1] ? 4'b1100 : 4'b0011);
      ACC_WORD: m = (off == 2'd0) ? 4'b1111 : 4'b0000;
      default:  m = 4'b0000;
    endcase
    return m;
  endfunction

  // Move a bit-0 aligned value onto its byte lanes.
  function automatic logic [BUS_W-1:0] to_lanes(input logic [BUS_W-1:0] d, input logic [1:0] off);
    return d << {off, 3'b000};
  endfunction

  // Pull the addressed lanes of a register word down to bit 0 and trim to size.
  function automatic logic [BUS_W-1:0] from_lanes(input logic [BUS_W-1:0] w,
                                                  input logic [1:0] off,
                                                  input logic [1:0] size);
    logic [BUS_W-1:0] s;
    s = w >> {off, 3'b000};
    case (acc_size_e'(size))
      ACC_BYTE: s = s & 32'h0000_00FF;
      ACC_HALF: s = s & 32'h0000_FFFF;
      default:  s = s;
    endcase
    return s;
  endfunction

  // Expand a lane mask into a bit mask.
  function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [BUS_W-1:0] b;
    for (int i = 0; i < LANES; i++) b[i*8 +: 8] = {8{be[i]}};
    return b;
  endfunction

  // Write-one-to-clear with set priority.
  function automatic logic w1c_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_hub_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] PAIR_OFS = 12'h200,
  parameter logic [11:0] IME_OFS  = 12'h208,
  parameter logic [11:0] SYS_OFS  = 12'h300
) (
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [LANES-1:0]  be,
  output logic [BUS_W-1:0]  wlanes,
  output logic              sel_pair,
  output logic              sel_ime,
  output logic              sel_sys,
  output logic              wr_en,
  output logic              rd_en,
  output logic              halt_cmd
);

  logic [ADDR_W-1:0] word_addr;
  logic              any_lane;

  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign be        = lane_mask(bus_size, bus_addr[1:0]);
  assign any_lane  = |be;
  assign wlanes    = to_lanes(bus_wdata, bus_addr[1:0]);

  assign sel_pair  = (word_addr == ADDR_W'(PAIR_OFS));
  assign sel_ime   = (word_addr == ADDR_W'(IME_OFS));
  assign sel_sys   = (word_addr == ADDR_W'(SYS_OFS));

  assign wr_en     = bus_req &  bus_wr & any_lane;
  assign rd_en     = bus_req & ~bus_wr & any_lane;

  // Halt entry: byte store into lane 1 of the system word with bit 7 low.
  assign halt_cmd  = wr_en & sel_sys & (acc_size_e'(bus_size) == ACC_BYTE)
                   & be[1] & ~wlanes[15];

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [REG_W-1:0]   clr_bits,
  output logic [REG_W-1:0]   req_q
);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i < NUM_SRC) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q[i] <= 1'b0;
        else        req_q[i] <= w1c_next(req_q[i], clr_bits[i], src_pulse[i]);
      end
    end else begin : g_spare
      assign req_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd,
  input  logic wake,
  output logic halt_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halt_req <= 1'b0;
    else if (wake)     halt_req <= 1'b0;
    else if (halt_cmd) halt_req <= 1'b1;
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int          NUM_SRC  = 14,
  parameter int          REG_W    = 16,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] PAIR_OFS = 12'h200,
  parameter logic [11:0] IME_OFS  = 12'h208,
  parameter logic [11:0] SYS_OFS  = 12'h300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [13:0]        src_pulse,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               cpu_irq,
  output logic               halt_req
);

  localparam logic [REG_W-1:0] LIVE_MASK = REG_W'((1 << NUM_SRC) - 1);

  logic [LANES-1:0] be;
  logic [BUS_W-1:0] wlanes, wmask, wword;
  logic             sel_pair, sel_ime, sel_sys, wr_en, rd_en, halt_cmd;
  logic [REG_W-1:0] en_q, req_q, clr_bits;
  logic             ime_q, boot_q, pending;
  logic [BUS_W-1:0] rd_word;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .PAIR_OFS(PAIR_OFS), .IME_OFS(IME_OFS), .SYS_OFS(SYS_OFS)
  ) u_dec (
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .be(be), .wlanes(wlanes), .sel_pair(sel_pair),
    .sel_ime(sel_ime), .sel_sys(sel_sys), .wr_en(wr_en), .rd_en(rd_en),
    .halt_cmd(halt_cmd)
  );

  assign wmask = lane_bits(be);
  assign wword = wlanes & wmask;

  // Acknowledge bits come from the upper half of the enable/request word.
  assign clr_bits = (wr_en && sel_pair) ? (wword[31:16] & LIVE_MASK) : '0;

  irq_req_latch #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_req (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse[NUM_SRC-1:0]),
    .clr_bits(clr_bits), .req_q(req_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ime_q  <= 1'b0;
      boot_q <= 1'b0;
    end else if (wr_en) begin
      if (sel_pair)
        en_q <= ((en_q & ~wmask[15:0]) | wword[15:0]) & LIVE_MASK;
      if (sel_ime && be[0])
        ime_q <= wword[0];
      if (sel_sys && be[0])
        boot_q <= wword[0];
    end
  end

  assign pending = |(en_q & req_q);

  irq_halt_ctrl u_halt (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .wake(pending), .halt_req(halt_req)
  );

  always_comb begin
    rd_word = '0;
    if (sel_pair)     rd_word = {req_q, en_q};
    else if (sel_ime) rd_word = {{(BUS_W-1){1'b0}}, ime_q};
    else if (sel_sys) rd_word = {{(BUS_W-1){1'b0}}, boot_q};
  end

  assign bus_rdata = rd_en ? from_lanes(rd_word, bus_addr[1:0], bus_size) : '0;
  assign cpu_irq   = ime_q & pending;

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NUM_SRC = 14,
  parameter int REG_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [13:0]        src_pulse,
  input logic [REG_W-1:0]   req_q,
  input logic [REG_W-1:0]   en_q,
  input logic [REG_W-1:0]   clr_bits,
  input logic               ime_q,
  input logic               pending,
  input logic               halt_cmd,
  input logic               halt_req,
  input logic               cpu_irq
);

  logic [REG_W-1:0] pulse_ext;
  assign pulse_ext = REG_W'(src_pulse[NUM_SRC-1:0]);

  AST_PULSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_ext != '0 |=> (req_q & $past(pulse_ext)) == $past(pulse_ext)); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits & ~pulse_ext) != '0 |=> (req_q & $past(clr_bits & ~pulse_ext)) == '0); // R3

  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits & pulse_ext) != '0 |=> (req_q & $past(clr_bits & pulse_ext)) == $past(clr_bits & pulse_ext)); // R8

  AST_MASTER_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !ime_q |-> !cpu_irq); // R7

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[REG_W-1:NUM_SRC] == '0) && (en_q[REG_W-1:NUM_SRC] == '0)); // R9

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd && !pending |=> halt_req); // R10

  AST_HALT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !halt_req); // R11

endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .req_q(req_q), .en_q(en_q),
  .clr_bits(clr_bits), .ime_q(ime_q), .pending(pending), .halt_cmd(halt_cmd),
  .halt_req(halt_req), .cpu_irq(cpu_irq)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_pulse = '0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd3;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq, halt_req;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  irq_hub uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .halt_req(halt_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per read cycle, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_wr) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard actual=%h expected=<none>", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic drive(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                       input logic [31:0] d, input logic [13:0] p);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d; src_pulse = p;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_wr = 1'b0; bus_size = 2'd3; bus_wdata = '0; src_pulse = '0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
    drive(1'b1, sz, a, d, '0);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] e,
                    input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_size = sz; // set before drive for clarity; drive overrides identically
    drive(1'b0, sz, a, '0, '0);
  endtask

  task automatic pulse(input logic [13:0] p);
    @(posedge clk); #1; src_pulse = p;
    @(posedge clk); #1; src_pulse = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 irq", {31'b0, cpu_irq}, 32'h0);
    check("R1 halt", {31'b0, halt_req}, 32'h0);
    rd(SZ_W, 12'h200, 32'h0, "R1 pair word");
    rd(SZ_W, 12'h208, 32'h0, "R1 master");
    rd(SZ_B, 12'h300, 32'h0, "R12 boot after reset");

    pulse(14'h0009);
    rd(SZ_H, 12'h202, 32'h0009, "R2 latched requests");
    check("R7 irq with enable off", {31'b0, cpu_irq}, 32'h0);

    wr(SZ_W, 12'h200, 32'h0001_FFFF);
    rd(SZ_W, 12'h200, 32'h0008_3FFF, "R4 R9 enable load and ack");

    check("R7 irq with master off", {31'b0, cpu_irq}, 32'h0);
    wr(SZ_B, 12'h208, 32'h0000_00FF);
    rd(SZ_H, 12'h208, 32'h1, "R6 master set via byte");
    check("R7 irq asserted", {31'b0, cpu_irq}, 32'h1);
    wr(SZ_W, 12'h208, 32'hFFFF_FFFE);
    rd(SZ_W, 12'h208, 32'h0, "R6 only bit 0 kept");
    check("R7 irq dropped", {31'b0, cpu_irq}, 32'h0);

    wr(SZ_H, 12'h200, 32'h0000_0000);
    pulse(14'h3000);
    wr(SZ_H, 12'h202, 32'h0000_1008);
    rd(SZ_H, 12'h202, 32'h2000, "R3 selective ack");
    rd(SZ_B, 12'h203, 32'h20, "R5 byte lane of request");
    wr(SZ_B, 12'h201, 32'h0000_0012);
    rd(SZ_B, 12'h201, 32'h12, "R5 byte enable write");
    rd(SZ_H, 12'h200, 32'h1200, "R5 halfword enable read");

    drive(1'b1, SZ_H, 12'h202, 32'h0000_2000, 14'h2000);
    rd(SZ_H, 12'h202, 32'h2000, "R8 pulse beats ack");

    wr(SZ_B, 12'h301, 32'h0000_0080);
    check("R10 bit7 set ignored", {31'b0, halt_req}, 32'h0);
    wr(SZ_B, 12'h301, 32'h0000_0000);
    check("R10 halt entered", {31'b0, halt_req}, 32'h1);
    repeat (3) @(posedge clk);
    #1 check("R10 halt held", {31'b0, halt_req}, 32'h1);
    pulse(14'h1000);
    check("R11 halt one edge after pending", {31'b0, halt_req}, 32'h1);
    @(posedge clk); #1;
    check("R11 halt woke with master off", {31'b0, halt_req}, 32'h0);
    check("R11 irq stays low", {31'b0, cpu_irq}, 32'h0);

    wr(SZ_B, 12'h300, 32'h0000_0001);
    rd(SZ_B, 12'h300, 32'h1, "R12 boot flag set");
    rd(SZ_B, 12'h301, 32'h0, "R12 halt byte reads zero");

    rd(SZ_W, 12'h204, 32'h0, "R13 unmapped read");
    rd(SZ_H, 12'h201, 32'h0, "R13 misaligned read");
    rd(2'd3, 12'h200, 32'h0, "R13 size 3 read");
    wr(SZ_W, 12'h204, 32'hFFFF_FFFF);
    wr(SZ_H, 12'h201, 32'h0000_FFFF);
    wr(SZ_W, 12'h202, 32'hFFFF_FFFF);
    rd(SZ_W, 12'h200, 32'h3000_1200, "R13 stray writes ignored");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule